// File: doc/BRIEF.md
# Iterative Polynomial Cosine Unit

This block returns the cosine of a small non-negative angle. It takes a signed fixed-point angle between zero and pi/4 and evaluates an even polynomial of degree 12. The polynomial is rewritten as a polynomial of degree six in the squared angle. That polynomial is evaluated by Horner's rule, and the same multiply-accumulate path is used for every pass. The squared angle is formed once, in a setup cycle. The running value then starts at the highest coefficient and goes through six passes of the form "running value times squared angle, plus the next coefficient". Each pass takes three clock cycles: one to multiply, one to round back to the data format, and one to add.

A caller pulses `start` with the angle while the unit is idle. Exactly one cycle later than a fixed number of clock edges, `done` pulses and `cos_out` carries the result. The result stays on `cos_out` until the next evaluation completes. Requests that arrive while an evaluation is running are dropped.

Top module: `cos_horner_unit`

## Requirements
- R1: While reset is asserted and right after it is released, `done` is 0 and `cos_out` is 0.
- R2: Angle and result use signed fixed point with 14 fraction bits (the value is the integer divided by 16384). When the unit is idle, a high `start` at a rising edge latches `angle`.
- R3: `done` goes high for exactly one cycle, 19 rising edges after the edge that accepted `start`. That is 1 setup edge plus 6 passes of 3 edges.
- R4: A `start` seen while an evaluation is running is ignored. The running result is not changed by it, and no extra `done` follows it.
- R5: For every angle from 0 to 12868 (pi/4), `cos_out` is within 2 LSB of the rounded real cosine.
- R6: Angle 0 gives exactly 16384. Angle 12868 gives 11585 within 2 LSB.
- R7: Between two `done` pulses, `cos_out` holds the last result unchanged.
- R8: A `start` raised in the same cycle that `done` is high is accepted at the next edge, so evaluations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request; sampled only when idle |
| angle | input | 16 | Angle, signed with 14 fraction bits, 0 to 12868 |
| done | output | 1 | One-cycle pulse marking a new result |
| cos_out | output | 16 | Cosine, signed with 14 fraction bits |

## Verification
The bench builds the unit with its defaults: a 16-bit word, 14 fraction bits and a 3-cycle multiply-accumulate. With these values the whole legal angle range is only 12869 codes. So random angles and the two interval ends both fall inside a domain where the 2-LSB bound can be checked against a real-valued cosine. The same defaults fix the completion point at edge 19. The bench can therefore count that latency exactly, including runs where a second request arrives mid-evaluation and runs that start back to back.

// File: rtl/cos_horner_unit.sv
module cos_horner_unit #(
  parameter int DW      = 16,
  parameter int FRAC    = 14,
  parameter int MAC_CYC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] angle,
  output logic          done,
  output logic [DW-1:0] cos_out
);
  localparam int PW    = 2 * DW;
  localparam int ITERS = 6;
  localparam int ONE   = 1 << FRAC;
  localparam int HALF  = 1 << (FRAC - 1);
  localparam int PHW   = (MAC_CYC > 1) ? $clog2(MAC_CYC) : 1;
  localparam int ITW   = $clog2(ITERS);

  localparam int K5 =  ((ONE + 239500800) / 479001600);
  localparam int K4 = -((ONE + 1814400) / 3628800);
  localparam int K3 =  ((ONE + 20160) / 40320);
  localparam int K2 = -((ONE + 360) / 720);
  localparam int K1 =  ((ONE + 12) / 24);
  localparam int K0 = -(ONE / 2);

  typedef enum logic [1:0] {IDLE, SQR, RUN} state_t;

  state_t               st;
  logic signed [DW-1:0] xr, x2, acc, scl, res;
  logic signed [PW-1:0] prod, sq;
  logic [PHW-1:0]       ph;
  logic [ITW-1:0]       it;
  logic                 done_q;

  function automatic logic signed [DW-1:0] coef(input logic [ITW-1:0] i);
    case (i)
      3'd0:    return DW'(K4);
      3'd1:    return DW'(K3);
      3'd2:    return DW'(K2);
      3'd3:    return DW'(K1);
      3'd4:    return DW'(K0);
      default: return DW'(ONE);
    endcase
  endfunction

  function automatic logic signed [DW-1:0] rnd(input logic signed [PW-1:0] p);
    logic signed [PW-1:0] t;
    t = p + PW'(HALF);
    return t[FRAC +: DW];
  endfunction

  assign sq      = xr * xr;
  assign done    = done_q;
  assign cos_out = res;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IDLE;
      done_q <= 1'b0;
      res    <= '0;
      xr     <= '0;
      x2     <= '0;
      acc    <= '0;
      scl    <= '0;
      prod   <= '0;
      ph     <= '0;
      it     <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        IDLE: if (start) begin
          xr <= angle;
          st <= SQR;
        end
        SQR: begin
          x2  <= rnd(sq);
          acc <= DW'(K5);
          ph  <= '0;
          it  <= '0;
          st  <= RUN;
        end
        default: begin
          if (ph == PHW'(0)) prod <= acc * x2;
          if (ph == PHW'(1)) scl  <= rnd(prod);
          if (ph == PHW'(MAC_CYC - 1)) begin
            acc <= scl + coef(it);
            ph  <= '0;
            if (it == ITW'(ITERS - 1)) begin
              res    <= scl + coef(it);
              done_q <= 1'b1;
              st     <= IDLE;
            end else begin
              it <= it + 1'b1;
            end
          end else begin
            ph <= ph + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

module cos_horner_unit_chk #(
  parameter int DW  = 16,
  parameter int LAT = 19
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] cos_out,
  input logic [DW-1:0] xr
);
  logic [15:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (start && !busy) cnt <= '0;
    else if (busy)           cnt <= cnt + 1'b1;
  end

  assert_done_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cnt == 16'(LAT)));

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_start_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(xr));

  assert_done_ends_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_result_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(cos_out));
endmodule

bind cos_horner_unit cos_horner_unit_chk #(.DW(DW), .LAT(1 + 6 * MAC_CYC)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .busy   (st != IDLE),
  .done   (done),
  .cos_out(cos_out),
  .xr     (xr)
);

// File: tb/cos_horner_unit_test.sv
module cos_horner_unit_test;
  localparam int DW      = 16;
  localparam int LAT     = 19;
  localparam int ANG_MAX = 12868;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [DW-1:0] angle = '0;
  logic          done;
  logic [DW-1:0] cos_out;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  cos_horner_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .angle(angle),
    .done(done), .cos_out(cos_out)
  );

  always #10 clk = ~clk;

  function automatic int ideal(input int a);
    real r;
    r = $cos(real'(a) / 16384.0) * 16384.0;
    return $rtoi(r + 0.5);
  endfunction

  task automatic check(input string req, input int act, input int exp, input int tol);
    n_run++;
    if (act - exp > tol || exp - act > tol) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_one(input int a, input string req, input int tol);
    int waited;
    angle = DW'(a);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waited = 1;
    while (!done && waited < 60) begin
      @(negedge clk);
      waited++;
    end
    check("R3 latency", waited - 1, LAT, 0);
    check(req, int'($signed(cos_out)), ideal(a), tol);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int a;
    int held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 reset done", int'(done), 0, 0);
    check("R1 reset cos_out", int'(cos_out), 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release done", int'(done), 0, 0);
    check("R1 after release cos_out", int'(cos_out), 0, 0);

    run_one(0, "R6 zero angle exact", 0);
    check("R6 zero value", int'($signed(cos_out)), 16384, 0);
    @(negedge clk);
    check("R3 done one cycle", int'(done), 0, 0);
    run_one(ANG_MAX, "R6 pi/4", 2);
    check("R6 pi/4 value", int'($signed(cos_out)), 11585, 2);
    run_one(1, "R5 angle 1", 2);
    run_one(ANG_MAX - 1, "R5 near top", 2);
    run_one(8192, "R2 angle 0.5", 2);
    run_one(6434, "R5 pi/8", 2);

    // R8: each call starts in the cycle where the previous done is high
    run_one(3000, "R8 back to back a", 2);
    run_one(11000, "R8 back to back b", 2);

    // R4: extra request with another angle while busy
    angle = DW'(0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    angle = DW'(ANG_MAX);
    start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    angle = '0;
    held = 8;
    while (!done && held < 60) begin
      @(negedge clk);
      held++;
    end
    check("R4 busy start latency", held, LAT + 1, 0);
    check("R4 busy start ignored", int'($signed(cos_out)), 16384, 0);
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      check("R4 no extra done", int'(done), 0, 0);
    end
    check("R7 result held", int'($signed(cos_out)), 16384, 0);

    // R7: input changes without start do not alter the output
    for (int i = 0; i < 6; i++) begin
      angle = DW'(i * 2000);
      @(negedge clk);
      check("R7 hold without start", int'($signed(cos_out)), 16384, 0);
    end

    for (int i = 0; i < 60; i++) begin
      a = int'($urandom % (ANG_MAX + 1));
      run_one(a, "R5 random angle", 2);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule